// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block conditions and masks a set of shared external interrupt lines before they reach the processor pins. Each line is first synchronised. It is then qualified by a per-line polarity bit, a level/edge selection bit and a both-edges bit. A per-line pending bit is kept from the result. In level mode the pending bit tracks the qualified input. In edge mode it captures detected edges and holds them until software clears them.

Software controls the block through a simple word-addressed register port. The port has no handshake: a write is taken on the clock edge where the write enable is high, and read data is combinational from the address.

- **Configuration:** the per-line configuration bits sit in bit arrays, with line i in word i/32 at bit i%32.
- **Masking:** the mask is changed only by write-one-to-set and write-one-to-clear words, and it can be read back.
- **Edge register:** a single edge register sets or clears the pending bit of one numbered line.
- **Routing:** each line has a routing word that sends it to a numbered processor pin and/or to the non-maskable output.

Outputs are the vector of pending-and-unmasked lines, the per-pin request lines, the NMI request, and the packed routing fields.

Top module: `shared_irq_src_ctrl`

## Requirements
- R1: After reset the mask is all zero, every routing word reads zero, and pinIrq, nmiIrq and activeIrq are all low.
- R2: In level mode (trigger bit 0) the pending bit equals the input when the polarity bit is 1, and the inverted input when it is 0. A change on irqIn is visible in the pending word on the third rising clock edge after it, not earlier.
- R3: In edge mode (trigger bit 1) with the both-edges bit 0, a rising input edge (polarity 1) or a falling input edge (polarity 0) sets the pending bit. The bit then stays set after the input returns, until it is cleared through the edge register.
- R4: In edge mode with the both-edges bit 1, either input edge sets the pending bit, whatever the polarity bit holds.
- R5: A write to the edge register (byte offset 0x280) sets the pending bit of the line numbered in data bits 7:0 when data bit 31 is 1, and clears it when bit 31 is 0. The write has no effect on level-mode lines or on numbers at or above NUM_IRQ.
- R6: Writing the clear-mask word (0x300 + 4*w) clears the mask bits written as 1. Writing the set-mask word (0x380 + 4*w) sets the mask bits written as 1. Bits written as 0 leave the mask unchanged.
- R7: The mask words (0x400 + 4*w) and pending words (0x480 + 4*w) are read-only; writes to them change nothing.
- R8: Polarity (0x100), trigger (0x180) and both-edges (0x200) words hold line i at word i/32, bit i%32, and read back as written, with bits for absent lines reading 0.
- R9: The routing word of line i is at 0x500 + 4*i. Bit 31 enables pin routing, bit 30 enables NMI routing and bits 5:0 hold the pin number. Only these bits are stored and read back. mapOut holds {bit31, bit30, bits5:0} of line i in bits 8*i+7 down to 8*i.
- R10: pinIrq[p] is the OR of activeIrq over lines with pin routing enabled and pin number p, so a pin number at or above NUM_PINS drives no pin. nmiIrq is the OR of activeIrq over lines with NMI routing enabled.
- R11: activeIrq is the bitwise AND of the pending and mask bits; a pending but masked line drives no output.
- R12: When an edge event and an edge-register clear hit the same line in the same cycle, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | ADDR_W | Byte address of the register word |
| regWrEn | input | 1 | Write strobe, taken on the rising edge |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| irqIn | input | NUM_IRQ | Raw asynchronous interrupt lines |
| activeIrq | output | NUM_IRQ | Pending and unmasked lines |
| pinIrq | output | NUM_PINS | Per-pin interrupt requests |
| nmiIrq | output | 1 | Non-maskable interrupt request |
| mapOut | output | 8*NUM_IRQ | Packed routing fields per line |

## Verification
- **Input changes:** a change on irqIn reaches the pending bit on the third rising edge. Two flops of synchronisation come first, and the pending flop follows them. The bench drives inputs on a falling edge and reads three falling edges later. One check also confirms that the bit is still clear after only two.
- **Register writes:** a write takes effect on the single rising edge that samples it. Reads are combinational, so the bench reads on the falling edge right after the write. This also catches a one-cycle disturbance of a level-mode pending bit.
- **Pin outputs:** pinIrq, nmiIrq and activeIrq follow the registered pending and mask state with no extra delay, so they are sampled together with the register reads.
- **Same-cycle clear and edge:** the bench presents the edge-register write in the cycle before the third edge after the input change.

// File: rtl/sic_pkg.sv
package sic_pkg;

  localparam int OFS_POL  = 'h100;
  localparam int OFS_TRIG = 'h180;
  localparam int OFS_DUAL = 'h200;
  localparam int OFS_EDGE = 'h280;
  localparam int OFS_CLRM = 'h300;
  localparam int OFS_SETM = 'h380;
  localparam int OFS_MASK = 'h400;
  localparam int OFS_PEND = 'h480;
  localparam int OFS_MAP  = 'h500;

  typedef enum logic [2:0] {
    RD_NONE, RD_POL, RD_TRIG, RD_DUAL, RD_MASK, RD_PEND, RD_MAP
  } rd_kind_e;

  typedef struct packed {
    logic     wrPol;
    logic     wrTrig;
    logic     wrDual;
    logic     wrClrMask;
    logic     wrSetMask;
    logic     wrEdge;
    logic     wrMap;
    logic [7:0] wordIdx;
    logic [7:0] mapIdx;
    rd_kind_e rdKind;
  } sic_strobe_t;

endpackage

// File: rtl/sic_ctrl.sv
module sic_ctrl
  import sic_pkg::*;
#(
  parameter int NUM_IRQ = 40,
  parameter int ADDR_W  = 12
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output sic_strobe_t       st
);

  localparam int MAP_END = OFS_MAP + 4 * NUM_IRQ;

  int unsigned addrInt;
  int unsigned grp;
  logic        aligned;
  logic        inMap;

  always_comb begin
    addrInt = int'(regAddr);
    grp     = addrInt >> 7;
    aligned = (regAddr[1:0] == 2'b00);
    inMap   = aligned && (addrInt >= OFS_MAP) && (addrInt < MAP_END);
    st          = '0;
    st.rdKind   = RD_NONE;
    st.wordIdx  = 8'(regAddr[6:2]);
    st.mapIdx   = 8'((addrInt - OFS_MAP) >> 2);
    if (inMap) begin
      st.wrMap  = regWrEn;
      st.rdKind = RD_MAP;
    end else if (aligned) begin
      case (grp)
        OFS_POL  >> 7: begin st.wrPol  = regWrEn; st.rdKind = RD_POL;  end
        OFS_TRIG >> 7: begin st.wrTrig = regWrEn; st.rdKind = RD_TRIG; end
        OFS_DUAL >> 7: begin st.wrDual = regWrEn; st.rdKind = RD_DUAL; end
        OFS_EDGE >> 7: st.wrEdge = regWrEn && (addrInt == OFS_EDGE);
        OFS_CLRM >> 7: st.wrClrMask = regWrEn;
        OFS_SETM >> 7: st.wrSetMask = regWrEn;
        OFS_MASK >> 7: st.rdKind = RD_MASK;
        OFS_PEND >> 7: st.rdKind = RD_PEND;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sic_datapath.sv
module sic_datapath
  import sic_pkg::*;
#(
  parameter int NUM_IRQ  = 40,
  parameter int NUM_PINS = 4,
  parameter int PIN_W    = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sic_strobe_t          st,
  input  logic [31:0]          wrData,
  input  logic [NUM_IRQ-1:0]   irqIn,
  output logic [31:0]          rdData,
  output logic [NUM_IRQ-1:0]   pendVec,
  output logic [NUM_IRQ-1:0]   maskVec,
  output logic [NUM_IRQ-1:0]   trigVec,
  output logic [NUM_IRQ-1:0]   activeIrq,
  output logic [NUM_PINS-1:0]  pinIrq,
  output logic                 nmiIrq,
  output logic [8*NUM_IRQ-1:0] mapOut
);

  localparam int NUM_WORDS = (NUM_IRQ + 31) / 32;
  localparam int PAD_W     = NUM_WORDS * 32;

  logic [NUM_IRQ-1:0] syncA, syncB, syncC;
  logic [NUM_IRQ-1:0] polVec, dualVec, toPinVec, toNmiVec;
  logic [PIN_W-1:0]   pinSel  [NUM_IRQ];
  logic [31:0]        mapWord [NUM_IRQ];

  // two-flop synchroniser plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      syncC <= '0;
    end else begin
      syncA <= irqIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    localparam int W = i / 32;
    localparam int B = i % 32;
    logic             polR, trigR, dualR, maskR, pendR, toPinR, toNmiR;
    logic [PIN_W-1:0] pinR;
    logic             wordHit, edgeHit, riseEv, fallEv, lineEv, qualLvl;

    assign wordHit = (st.wordIdx == 8'(W));
    assign edgeHit = st.wrEdge && (wrData[7:0] == 8'(i));
    assign riseEv  = syncB[i] & ~syncC[i];
    assign fallEv  = ~syncB[i] & syncC[i];
    assign lineEv  = dualR ? (riseEv | fallEv) : (polR ? riseEv : fallEv);
    assign qualLvl = polR ? syncB[i] : ~syncB[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        polR <= 1'b0; trigR <= 1'b0; dualR <= 1'b0; maskR <= 1'b0;
        pendR <= 1'b0; toPinR <= 1'b0; toNmiR <= 1'b0; pinR <= '0;
      end else begin
        if (st.wrPol  && wordHit) polR  <= wrData[B];
        if (st.wrTrig && wordHit) trigR <= wrData[B];
        if (st.wrDual && wordHit) dualR <= wrData[B];
        if (st.wrSetMask && wordHit && wrData[B])      maskR <= 1'b1;
        else if (st.wrClrMask && wordHit && wrData[B]) maskR <= 1'b0;
        if (st.wrMap && (st.mapIdx == 8'(i))) begin
          toPinR <= wrData[31];
          toNmiR <= wrData[30];
          pinR   <= wrData[PIN_W-1:0];
        end
        if (!trigR)       pendR <= qualLvl;
        else if (lineEv)  pendR <= 1'b1;
        else if (edgeHit) pendR <= wrData[31];
      end
    end

    assign polVec[i]   = polR;
    assign trigVec[i]  = trigR;
    assign dualVec[i]  = dualR;
    assign maskVec[i]  = maskR;
    assign pendVec[i]  = pendR;
    assign toPinVec[i] = toPinR;
    assign toNmiVec[i] = toNmiR;
    assign pinSel[i]   = pinR;
    assign mapWord[i]  = {toPinR, toNmiR, {(30-PIN_W){1'b0}}, pinR};
    assign mapOut[8*i +: 8] = {toPinR, toNmiR, 6'(pinR)};
  end

  assign activeIrq = pendVec & maskVec;

  always_comb begin
    nmiIrq = 1'b0;
    for (int p = 0; p < NUM_PINS; p++) pinIrq[p] = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (toNmiVec[i] && activeIrq[i]) nmiIrq = 1'b1;
      for (int p = 0; p < NUM_PINS; p++)
        if (toPinVec[i] && activeIrq[i] && (pinSel[i] == PIN_W'(p))) pinIrq[p] = 1'b1;
    end
  end

  logic [PAD_W-1:0] selPad;
  int unsigned      wIdx;
  int unsigned      mIdx;

  always_comb begin
    wIdx = int'(st.wordIdx);
    mIdx = int'(st.mapIdx);
    case (st.rdKind)
      RD_POL:  selPad = PAD_W'(polVec);
      RD_TRIG: selPad = PAD_W'(trigVec);
      RD_DUAL: selPad = PAD_W'(dualVec);
      RD_MASK: selPad = PAD_W'(maskVec);
      RD_PEND: selPad = PAD_W'(pendVec);
      default: selPad = '0;
    endcase
    rdData = '0;
    if (st.rdKind == RD_MAP) begin
      if (mIdx < NUM_IRQ) rdData = mapWord[mIdx];
    end else if (wIdx < NUM_WORDS) begin
      rdData = selPad[wIdx*32 +: 32];
    end
  end

endmodule

// File: rtl/shared_irq_src_ctrl.sv
module shared_irq_src_ctrl
  import sic_pkg::*;
#(
  parameter int NUM_IRQ  = 40,
  parameter int NUM_PINS = 4,
  parameter int ADDR_W   = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic [NUM_IRQ-1:0]   irqIn,
  output logic [NUM_IRQ-1:0]   activeIrq,
  output logic [NUM_PINS-1:0]  pinIrq,
  output logic                 nmiIrq,
  output logic [8*NUM_IRQ-1:0] mapOut
);

  sic_strobe_t        strobe;
  logic [NUM_IRQ-1:0] pendVec, maskVec, trigVec;

  sic_ctrl #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .st(strobe)
  );

  sic_datapath #(.NUM_IRQ(NUM_IRQ), .NUM_PINS(NUM_PINS), .PIN_W(6)) u_dp (
    .clk(clk), .rstN(rstN), .st(strobe), .wrData(regWrData), .irqIn(irqIn),
    .rdData(regRdData), .pendVec(pendVec), .maskVec(maskVec), .trigVec(trigVec),
    .activeIrq(activeIrq), .pinIrq(pinIrq), .nmiIrq(nmiIrq), .mapOut(mapOut)
  );

endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
  parameter int NUM_IRQ  = 40,
  parameter int NUM_PINS = 4,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                regWrEn,
  input logic [31:0]         regWrData,
  input logic [NUM_IRQ-1:0]  maskVec,
  input logic [NUM_IRQ-1:0]  pendVec,
  input logic [NUM_IRQ-1:0]  trigVec,
  input logic [NUM_IRQ-1:0]  activeIrq,
  input logic [NUM_PINS-1:0] pinIrq,
  input logic                nmiIrq
);

  logic roWrite;
  assign roWrite = regWrEn && (int'(regAddr) >= 'h400) && (int'(regAddr) < 'h500);

  p_pin_needs_active_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pinIrq != '0) |-> (activeIrq != '0));

  p_nmi_needs_active_r10: assert property (@(posedge clk) disable iff (!rstN)
    nmiIrq |-> (activeIrq != '0));

  p_active_masked_r11: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == '0) |-> (activeIrq == '0));

  p_set_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'('h380) && regWrData[0]) |=> maskVec[0]);

  p_clr_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'('h300) && regWrData[0]) |=> !maskVec[0]);

  p_ro_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    roWrite |=> $stable(maskVec));

  p_edge_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (trigVec[0] && pendVec[0]
     && !(regWrEn && regAddr == ADDR_W'('h180))
     && !(regWrEn && regAddr == ADDR_W'('h280) && !regWrData[31] && regWrData[7:0] == 8'd0))
    |=> pendVec[0]);

endmodule

bind shared_irq_src_ctrl sic_checker #(
  .NUM_IRQ(NUM_IRQ), .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .maskVec(maskVec), .pendVec(pendVec),
  .trigVec(trigVec), .activeIrq(activeIrq), .pinIrq(pinIrq), .nmiIrq(nmiIrq)
);

// File: tb/shared_irq_src_ctrl_test.sv
module shared_irq_src_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NIRQ  = 40;
  localparam int NPINS = 4;
  localparam int AW    = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [AW-1:0]     regAddr = '0;
  logic              regWrEn = 1'b0;
  logic [31:0]       regWrData = '0;
  logic [31:0]       regRdData;
  logic [NIRQ-1:0]   irqIn = '0;
  logic [NIRQ-1:0]   activeIrq;
  logic [NPINS-1:0]  pinIrq;
  logic              nmiIrq;
  logic [8*NIRQ-1:0] mapOut;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_irq_src_ctrl #(.NUM_IRQ(NIRQ), .NUM_PINS(NPINS), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irqIn(irqIn),
    .activeIrq(activeIrq), .pinIrq(pinIrq), .nmiIrq(nmiIrq), .mapOut(mapOut)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    regAddr = AW'(a); regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    regAddr = AW'(a);
    #1 d = regRdData;
  endtask

  task automatic rdchk(input string tag, input int a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, {32'd0, d}, {32'd0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", total, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(2);

    // R1 reset state
    rdchk("R1 mask word0", 'h400, 32'h0);
    rdchk("R1 mask word1", 'h404, 32'h0);
    rdchk("R1 map word 0", 'h500, 32'h0);
    check("R1 pins", {60'd0, pinIrq}, 64'd0);
    check("R1 nmi", {63'd0, nmiIrq}, 64'd0);
    check("R1 active", {24'd0, activeIrq}, 64'd0);

    // R8 polarity array layout
    wr('h100, 32'hFFFF_FFFF);
    wr('h104, 32'hFFFF_FFFF);
    rdchk("R8 pol word1 absent bits", 'h104, 32'h0000_00FF);
    rdchk("R8 pol word0", 'h100, 32'hFFFF_FFFF);
    wr('h200, 32'h0000_5A00);
    rdchk("R8 dual readback", 'h200, 32'h0000_5A00);
    wr('h200, 32'h0);
    cyc(2);

    // R2 latency
    irqIn[5] = 1'b1;
    cyc(2);
    rdchk("R2 not before third edge", 'h480, 32'h0);
    cyc(1);
    rdchk("R2 on third edge", 'h480, 32'h20);
    irqIn[5] = 1'b0;
    cyc(4);

    // R2 level sweep over every line, active high
    for (int i = 0; i < NIRQ; i++) begin
      irqIn[i] = 1'b1;
      cyc(3);
      rdchk("R2 level high sweep", 'h480 + 4*(i/32), 32'h1 << (i % 32));
      irqIn[i] = 1'b0;
      cyc(3);
    end

    // R2 active low
    wr('h100, 32'h0);
    cyc(2);
    rdchk("R2 active-low idle", 'h480, 32'hFFFF_FFFF);
    irqIn[3] = 1'b1;
    cyc(3);
    rdchk("R2 active-low asserted line", 'h480, 32'hFFFF_FFF7);
    irqIn[3] = 1'b0;
    wr('h100, 32'hFFFF_FFFF);
    cyc(4);
    rdchk("R2 restored polarity", 'h480, 32'h0);

    // R6 mask set/clear
    wr('h380, 32'h5);
    rdchk("R6 set mask", 'h400, 32'h5);
    wr('h380, 32'h10);
    rdchk("R6 set keeps others", 'h400, 32'h15);
    wr('h300, 32'h1);
    rdchk("R6 clear one bit", 'h400, 32'h14);
    wr('h300, 32'h0);
    rdchk("R6 zero clear no effect", 'h400, 32'h14);
    wr('h384, 32'h80);
    rdchk("R6 set word1 line 39", 'h404, 32'h80);

    // R7 read-only words
    wr('h400, 32'hFFFF_FFFF);
    rdchk("R7 mask write ignored", 'h400, 32'h14);
    wr('h480, 32'hFFFF_FFFF);
    rdchk("R7 pend write ignored", 'h480, 32'h0);
    wr('h300, 32'hFFFF_FFFF);
    wr('h304, 32'hFFFF_FFFF);
    rdchk("R6 clear all", 'h400, 32'h0);

    // R3 single edge, rising
    wr('h180, 32'hFFFF_FFFF);
    wr('h184, 32'hFFFF_FFFF);
    cyc(2);
    irqIn[2] = 1'b1;
    cyc(3);
    rdchk("R3 rising edge sets", 'h480, 32'h4);
    irqIn[2] = 1'b0;
    cyc(4);
    rdchk("R3 sticky after release", 'h480, 32'h4);
    wr('h280, 32'h0000_0002);
    rdchk("R5 edge-register clear", 'h480, 32'h0);

    // R3 falling edge
    wr('h100, 32'hFFFF_FFFB);
    cyc(2);
    irqIn[2] = 1'b1;
    cyc(4);
    rdchk("R3 rising ignored in falling mode", 'h480, 32'h0);
    irqIn[2] = 1'b0;
    cyc(3);
    rdchk("R3 falling edge sets", 'h480, 32'h4);
    wr('h280, 32'h0000_0002);
    wr('h100, 32'hFFFF_FFFF);

    // R4 both edges
    wr('h200, 32'h10);
    cyc(2);
    irqIn[4] = 1'b1;
    cyc(3);
    rdchk("R4 rise in dual mode", 'h480, 32'h10);
    wr('h280, 32'h0000_0004);
    rdchk("R4 cleared", 'h480, 32'h0);
    irqIn[4] = 1'b0;
    cyc(3);
    rdchk("R4 fall in dual mode", 'h480, 32'h10);
    wr('h280, 32'h0000_0004);

    // R5 set through edge register, level lines and out-of-range number
    wr('h280, 32'h8000_0006);
    rdchk("R5 edge-register set", 'h480, 32'h40);
    wr('h280, 32'h0000_0006);
    rdchk("R5 edge-register clear 6", 'h480, 32'h0);
    wr('h184, 32'h0);
    wr('h280, 32'h8000_0021);
    rdchk("R5 level line unaffected", 'h484, 32'h0);
    wr('h280, 32'h8000_00C8);
    rdchk("R5 out-of-range word0", 'h480, 32'h0);
    rdchk("R5 out-of-range word1", 'h484, 32'h0);

    // R12 edge event beats a same-cycle clear
    wr('h280, 32'h8000_0002);
    irqIn[2] = 1'b1;
    cyc(2);
    regAddr = AW'('h280); regWrData = 32'h0000_0002; regWrEn = 1'b1;
    cyc(1);
    regWrEn = 1'b0;
    rdchk("R12 event wins over clear", 'h480, 32'h4);
    irqIn[2] = 1'b0;
    wr('h280, 32'h0000_0002);

    // R9 routing words
    wr('h500 + 4*7, 32'h8000_0002);
    rdchk("R9 map readback line7", 'h500 + 4*7, 32'h8000_0002);
    wr('h500 + 4*8, 32'hFFFF_FFFF);
    rdchk("R9 only routing bits kept", 'h500 + 4*8, 32'hC000_003F);
    check("R9 mapOut line7", {56'd0, mapOut[8*7 +: 8]}, 64'h82);
    check("R9 mapOut line8", {56'd0, mapOut[8*8 +: 8]}, 64'hFF);

    // R11 / R10 outputs
    wr('h280, 32'h8000_0007);
    #1 check("R11 masked pend gives no pin", {60'd0, pinIrq}, 64'd0);
    check("R11 masked pend not active", {24'd0, activeIrq}, 64'd0);
    wr('h380, 32'h80);
    #1 check("R10 pin 2 raised", {60'd0, pinIrq}, 64'h4);
    check("R11 active line7", {24'd0, activeIrq}, 64'h80);
    check("R10 no nmi yet", {63'd0, nmiIrq}, 64'd0);
    wr('h280, 32'h8000_0008);
    wr('h380, 32'h100);
    #1 check("R10 nmi from line8", {63'd0, nmiIrq}, 64'd1);
    check("R10 pin 63 drives none", {60'd0, pinIrq}, 64'h4);
    wr('h300, 32'h80);
    #1 check("R10 pin drops on mask clear", {60'd0, pinIrq}, 64'd0);
    check("R10 nmi held", {63'd0, nmiIrq}, 64'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end

endmodule